// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial flash memory and decides, for every write-type command, whether it may go ahead. The byte carries a busy flag, a write-enable latch, a four-bit protection level, a quad-mode bit and a bit that freezes the status byte. The command decoder presents one qualified opcode strobe at a time, together with a flag saying that chip select rose on a whole byte. It also presents the data byte of a status write, the level of the write-protect pin, the target address and the busy line of the array sequencer.

The block answers in three ways. It drives the status byte for read-out. It holds a grant to the array sequencer while an accepted program or erase waits to start. It gives a combinational flag telling whether the current address falls in the protected top region of the 256 blocks of 64 KB each. The protection level picks how many top blocks are shielded. The write-protect pin, together with the freeze bit, can lock the status byte. That lock lapses while quad mode turns the pin into a data line.

A four-state machine drives the sequencing. The states are `S_IDLE`, `S_SRWR`, `S_ARM` and `S_BUSY`, with these transitions:
- `S_IDLE` to `S_SRWR`: a status write is accepted.
- `S_IDLE` to `S_ARM`: a program or erase is granted.
- `S_SRWR` to `S_IDLE`: the write timer expires.
- `S_ARM` to `S_BUSY`: the sequencer raises busy.
- `S_BUSY` to `S_IDLE`: busy falls.

Top module: `swp_status_guard`

## Requirements
- R1: After reset the status byte reads 00h and the grant is low. Status bit layout: bit 0 busy flag, bit 1 write-enable latch, bits 5:2 protection level with bit 2 as LSB, bit 6 quad enable, bit 7 freeze bit.
- R2: A write-enable strobe sets the latch on the next clock edge and a write-disable strobe clears it. Both have no effect while the busy flag is 1.
- R3: A strobe is acted on only if the byte-boundary flag is high in the same cycle. Without the flag the strobe changes nothing.
- R4: An accepted status write loads data bits 7:2 into status bits 7:2 at the next clock edge and clears the latch. It holds the busy flag at 1 for SRWR_CYCLES cycles. Data bits 1:0 are ignored.
- R5: A status write is ignored when the latch is 0 or the busy flag is 1. The busy flag is 1 while the state is not `S_IDLE` or while the sequencer busy input is high.
- R6: With the write-protect pin low, the freeze bit 1 and quad enable 0, a status write is refused and the whole status byte stays as it was, latch included. With the pin high, or the freeze bit 0, the byte stays writable.
- R7: With quad enable 1, the pin and the freeze bit no longer lock the status byte.
- R8: The block index is address bits 23:16. Level 0 protects no block. Level L from 1 to 7 protects the top 2^L blocks. Level 8 and above protects all 256 blocks. The flag follows the address and the level in the same cycle.
- R9: A program or erase with the latch set, the busy flag 0 and an unprotected address raises the grant from the next cycle. The grant stays high until the sequencer busy input is seen high. The busy flag reads 1 from the grant until one cycle after the busy input falls.
- R10: A program or erase to a protected address never raises the grant. It clears the latch at the next edge and leaves the busy flag at 0.
- R11: A program or erase with the latch at 0 is ignored.
- R12: The latch is cleared when a granted operation completes, that is on the edge where `S_BUSY` sees the busy input low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable opcode strobe |
| cmd_wrdi | input | 1 | Write-disable opcode strobe |
| cmd_wrsr | input | 1 | Status write opcode strobe |
| cmd_prog | input | 1 | Page program opcode strobe |
| cmd_erase | input | 1 | Erase opcode strobe |
| cs_edge_ok | input | 1 | Chip select rose on a byte boundary |
| wr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| addr | input | ADDR_W | Target address of program or erase |
| array_busy | input | 1 | Busy line from the array sequencer |
| status_o | output | 8 | Status byte |
| wr_allowed | output | 1 | Grant to the array sequencer |
| addr_protected | output | 1 | Target address lies in the protected region |

## Verification
Two coincidences are provoked on purpose. In the first, the write-protect pin falls in the same cycle as a status write that sets the freeze bit. The bench expects that write to be accepted, because the lock is judged on the freeze bit held before the edge, and it expects the very next status write to be refused. In the second, the sequencer drops busy in the same cycle as a write-enable strobe arrives. The bench expects a cleared latch after that edge, because completion wins and the busy flag still reads 1 when the strobe is seen.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int ST_WIP   = 0;
    localparam int ST_WEL   = 1;
    localparam int ST_BP_LO = 2;
    localparam int ST_BP_W  = 4;
    localparam int ST_QE    = 6;
    localparam int ST_SRWD  = 7;
    localparam int ST_W     = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SRWR = 2'd1,
        S_ARM  = 2'd2,
        S_BUSY = 2'd3
    } swp_state_e;
endpackage

// File: rtl/swp_region.sv
module swp_region #(
    parameter int BLK_W = 8,
    parameter int LVL_W = 4
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [LVL_W-1:0] level,
    output logic             prot
);
    logic [BLK_W-1:0] bit_ok;

    // Bit i of the block index must be 1 when i is at or above the level.
    for (genvar i = 0; i < BLK_W; i++) begin : g_bit
        assign bit_ok[i] = blk[i] || (int'(level) > i);
    end

    assign prot = (level != '0) && (&bit_ok);
endmodule

// File: rtl/swp_policy.sv
module swp_policy (
    input  logic wip,
    input  logic wel,
    input  logic srwd,
    input  logic qe,
    input  logic wp_n,
    input  logic prot,
    output logic hw_lock,
    output logic sr_write_ok,
    output logic pe_ok,
    output logic pe_blocked
);
    always_comb begin
        hw_lock     = !wp_n && srwd && !qe;
        sr_write_ok = !wip && wel && !hw_lock;
        pe_ok       = !wip && wel && !prot;
        pe_blocked  = !wip && wel && prot;
    end
endmodule

// File: rtl/swp_timer.sv
module swp_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/swp_status_guard.sv
module swp_status_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int BLK_W       = 8,
    parameter int SRWR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_prog,
    input  logic              cmd_erase,
    input  logic              cs_edge_ok,
    input  logic [ST_W-1:0]   wr_data,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              array_busy,
    output logic [ST_W-1:0]   status_o,
    output logic              wr_allowed,
    output logic              addr_protected
);
    localparam int BLK_LSB = ADDR_W - BLK_W;

    swp_state_e state, state_nx;
    logic               wel;
    logic [ST_BP_W-1:0] bp;
    logic               qe;
    logic               srwd;
    logic               wip;

    logic go_wren, go_wrdi, go_wrsr, go_pe;
    logic hw_lock, sr_write_ok, pe_ok, pe_blocked;
    logic timer_done;
    logic unused_bits;

    assign unused_bits = ^{addr[BLK_LSB-1:0], wr_data[ST_WEL:ST_WIP]};

    assign go_wren = cmd_wren && cs_edge_ok;
    assign go_wrdi = cmd_wrdi && cs_edge_ok;
    assign go_wrsr = cmd_wrsr && cs_edge_ok;
    assign go_pe   = (cmd_prog || cmd_erase) && cs_edge_ok;

    assign wip = (state != S_IDLE) || array_busy;

    swp_region #(.BLK_W(BLK_W), .LVL_W(ST_BP_W)) u_region (
        .blk   (addr[ADDR_W-1:BLK_LSB]),
        .level (bp),
        .prot  (addr_protected)
    );

    swp_policy u_policy (
        .wip         (wip),
        .wel         (wel),
        .srwd        (srwd),
        .qe          (qe),
        .wp_n        (wp_n),
        .prot        (addr_protected),
        .hw_lock     (hw_lock),
        .sr_write_ok (sr_write_ok),
        .pe_ok       (pe_ok),
        .pe_blocked  (pe_blocked)
    );

    swp_timer #(.CYCLES(SRWR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_SRWR),
        .done  (timer_done)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (go_wrsr && sr_write_ok)   state_nx = S_SRWR;
                else if (go_pe && pe_ok)      state_nx = S_ARM;
            end
            S_SRWR: if (timer_done)           state_nx = S_IDLE;
            S_ARM:  if (array_busy)           state_nx = S_BUSY;
            S_BUSY: if (!array_busy)          state_nx = S_IDLE;
            default:                          state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            bp   <= '0;
            qe   <= 1'b0;
            srwd <= 1'b0;
        end else if (go_wrsr && sr_write_ok) begin
            bp   <= wr_data[ST_BP_LO +: ST_BP_W];
            qe   <= wr_data[ST_QE];
            srwd <= wr_data[ST_SRWD];
            wel  <= 1'b0;
        end else if (go_pe && pe_blocked) begin
            wel  <= 1'b0;
        end else if (state == S_BUSY && !array_busy) begin
            wel  <= 1'b0;
        end else if (go_wrdi && !wip) begin
            wel  <= 1'b0;
        end else if (go_wren && !wip) begin
            wel  <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        status_o                       = '0;
        status_o[ST_WIP]               = wip;
        status_o[ST_WEL]               = wel;
        status_o[ST_BP_LO +: ST_BP_W]  = bp;
        status_o[ST_QE]                = qe;
        status_o[ST_SRWD]              = srwd;
        wr_allowed                     = (state == S_ARM);
    end

    // R2: an accepted write-enable sets the latch
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && cs_edge_ok && !status_o[ST_WIP] && !cmd_wrdi &&
         !cmd_wrsr && !cmd_prog && !cmd_erase) |=> status_o[ST_WEL]);

    // R4: any change of the upper status bits comes with busy and a cleared latch
    a_r4_change_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o[ST_W-1:ST_BP_LO]) |-> (status_o[ST_WIP] && !status_o[ST_WEL]));

    // R6: a locked status byte keeps its upper bits
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_o[ST_SRWD] && !status_o[ST_QE]) |=> $stable(status_o[ST_W-1:ST_BP_LO]));

    // R9: a grant only follows a set latch, an idle block and a free address
    a_r9_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_allowed) |-> ($past(status_o[ST_WEL]) && !$past(status_o[ST_WIP]) &&
                               !$past(addr_protected)));

    // R10: a protected target never produces a grant
    a_r10_protected_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_prog || cmd_erase) && cs_edge_ok && addr_protected && !status_o[ST_WIP])
        |=> !wr_allowed);

    // R12: completion clears the latch
    a_r12_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !array_busy) |=> !status_o[ST_WEL]);
endmodule

// File: tb/swp_status_guard_bench.sv
module swp_status_guard_bench;
    localparam logic [2:0] OP_NONE = 3'd0, OP_WREN = 3'd1, OP_WRDI = 3'd2,
                           OP_WRSR = 3'd3, OP_PROG = 3'd4, OP_ERASE = 3'd5;

    // {req[32:29], op[28:26], data[25:18], wp_n[17], blk[16:9], exp_status[8:1], exp_prot[0]}
    localparam int NV = 21;
    localparam logic [32:0] VEC [NV] = '{
        {4'd2,  OP_WREN,  8'h00, 1'b1, 8'h00, 8'h02, 1'b0},  // R2
        {4'd2,  OP_WRDI,  8'h00, 1'b1, 8'h00, 8'h00, 1'b0},  // R2
        {4'd5,  OP_WRSR,  8'h0C, 1'b1, 8'h00, 8'h00, 1'b0},  // R5 no latch
        {4'd2,  OP_WREN,  8'h00, 1'b1, 8'h00, 8'h02, 1'b0},
        {4'd4,  OP_WRSR,  8'h0F, 1'b1, 8'h00, 8'h0D, 1'b0},  // R4 low bits ignored
        {4'd11, OP_PROG,  8'h00, 1'b1, 8'hF8, 8'h0C, 1'b1},  // R11
        {4'd8,  OP_PROG,  8'h00, 1'b1, 8'hF7, 8'h0C, 1'b0},  // R8 boundary
        {4'd2,  OP_WREN,  8'h00, 1'b1, 8'h00, 8'h0E, 1'b0},
        {4'd10, OP_ERASE, 8'h00, 1'b1, 8'hFF, 8'h0C, 1'b1},  // R10
        {4'd2,  OP_WREN,  8'h00, 1'b1, 8'h00, 8'h0E, 1'b0},
        {4'd6,  OP_WRSR,  8'h8C, 1'b0, 8'h00, 8'h8D, 1'b0},  // R6 pin falls with freeze write
        {4'd2,  OP_WREN,  8'h00, 1'b0, 8'h00, 8'h8E, 1'b0},
        {4'd6,  OP_WRSR,  8'h00, 1'b0, 8'h00, 8'h8E, 1'b0},  // R6 locked
        {4'd6,  OP_WRSR,  8'h00, 1'b1, 8'h00, 8'h01, 1'b0},  // R6 pin high
        {4'd2,  OP_WREN,  8'h00, 1'b1, 8'h00, 8'h02, 1'b0},
        {4'd4,  OP_WRSR,  8'hC0, 1'b1, 8'h00, 8'hC1, 1'b0},  // R4
        {4'd2,  OP_WREN,  8'h00, 1'b0, 8'h00, 8'hC2, 1'b0},
        {4'd7,  OP_WRSR,  8'h80, 1'b0, 8'h00, 8'h81, 1'b0},  // R7 quad lifts lock
        {4'd2,  OP_WREN,  8'h00, 1'b0, 8'h00, 8'h82, 1'b0},
        {4'd6,  OP_WRSR,  8'h10, 1'b0, 8'h00, 8'h82, 1'b0},  // R6 lock returns
        {4'd6,  OP_WRSR,  8'h00, 1'b1, 8'h00, 8'h01, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
    logic        cmd_prog = 1'b0, cmd_erase = 1'b0, cs_edge_ok = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wp_n = 1'b1;
    logic [23:0] addr = '0;
    logic        array_busy = 1'b0;
    logic [7:0]  status_o;
    logic        wr_allowed;
    logic        addr_protected;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    swp_status_guard u_swp_status_guard (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cs_edge_ok(cs_edge_ok),
        .wr_data(wr_data), .wp_n(wp_n), .addr(addr), .array_busy(array_busy),
        .status_o(status_o), .wr_allowed(wr_allowed), .addr_protected(addr_protected)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] d, input logic wp, input logic [7:0] blk, input logic edge_ok);
        cmd_wren   = (op == OP_WREN);
        cmd_wrdi   = (op == OP_WRDI);
        cmd_wrsr   = (op == OP_WRSR);
        cmd_prog   = (op == OP_PROG);
        cmd_erase  = (op == OP_ERASE);
        cs_edge_ok = edge_ok;
        wr_data    = d;
        wp_n       = wp;
        addr       = {blk, 16'hA5C3};
    endtask

    task automatic idle_strobes();
        cmd_wren = 1'b0; cmd_wrdi = 1'b0; cmd_wrsr = 1'b0;
        cmd_prog = 1'b0; cmd_erase = 1'b0; cs_edge_ok = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 50 && status_o[0]; n++) @(negedge clk);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] d, input logic wp, input logic [7:0] blk);
        drive(op, d, wp, blk, 1'b1);
        @(negedge clk);
        idle_strobes();
    endtask

    function automatic logic exp_prot(input int lvl, input int blk);
        if (lvl == 0) return 1'b0;
        if (lvl >= 8) return 1'b1;
        return (blk >= 256 - (1 << lvl));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status after reset", status_o, 8'h00);
        chk("R1", "grant after reset", {7'b0, wr_allowed}, 8'h00);

        // R3 strobe without byte boundary
        drive(OP_WREN, 8'h00, 1'b1, 8'h00, 1'b0);
        @(negedge clk);
        idle_strobes();
        chk("R3", "wren without boundary", status_o, 8'h00);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][28:26], VEC[v][25:18], VEC[v][17], VEC[v][16:9], 1'b1);
            #1;
            chk($sformatf("R%0d", int'(VEC[v][32:29])), $sformatf("prot vec %0d", v),
                {7'b0, addr_protected}, {7'b0, VEC[v][0]});
            @(negedge clk);
            idle_strobes();
            chk($sformatf("R%0d", int'(VEC[v][32:29])), $sformatf("status vec %0d", v),
                status_o, VEC[v][8:1]);
            chk("R10", $sformatf("no grant vec %0d", v), {7'b0, wr_allowed}, 8'h00);
            wait_idle();
        end
        chk("R4", "busy time ends", status_o, 8'h00);

        // R8 level sweep
        for (int lvl = 0; lvl < 16; lvl++) begin
            do_op(OP_WREN, 8'h00, 1'b1, 8'h00);
            do_op(OP_WRSR, 8'(lvl << 2), 1'b1, 8'h00);
            wait_idle();
            for (int k = 0; k < 10; k++) begin
                int blk;
                blk = (k == 0) ? 0 : (k == 1) ? 127 : (k == 2) ? 128 : (k == 3) ? 191 :
                      (k == 4) ? 192 : (k == 5) ? 255 : (k == 6) ? 254 : (k == 7) ? 253 :
                      (k == 8) ? 240 : 239;
                addr = {8'(blk), 16'hFFFF};
                #1;
                chk("R8", $sformatf("level %0d block %0d", lvl, blk),
                    {7'b0, addr_protected}, {7'b0, exp_prot(lvl, blk)});
            end
        end
        do_op(OP_WREN, 8'h00, 1'b1, 8'h00);
        do_op(OP_WRSR, 8'h00, 1'b1, 8'h00);
        wait_idle();
        chk("R4", "levels cleared", status_o, 8'h00);

        // R9 / R12 granted program with sequencer handshake
        do_op(OP_WREN, 8'h00, 1'b1, 8'h10);
        do_op(OP_PROG, 8'h00, 1'b1, 8'h10);
        chk("R9", "grant raised", {7'b0, wr_allowed}, 8'h01);
        chk("R9", "status during grant", status_o, 8'h03);
        @(negedge clk);
        chk("R9", "grant held", {7'b0, wr_allowed}, 8'h01);
        array_busy = 1'b1;
        do_op(OP_WRSR, 8'hFC, 1'b1, 8'h10);
        chk("R9", "grant dropped on busy", {7'b0, wr_allowed}, 8'h00);
        chk("R5", "status write while busy ignored", status_o, 8'h03);
        do_op(OP_WRDI, 8'h00, 1'b1, 8'h10);
        chk("R2", "wrdi while busy ignored", status_o, 8'h03);
        array_busy = 1'b0;
        do_op(OP_WREN, 8'h00, 1'b1, 8'h10);
        chk("R12", "completion clears latch over wren", status_o, 8'h00);

        // R5 external busy while idle blocks write enable
        array_busy = 1'b1;
        do_op(OP_WREN, 8'h00, 1'b1, 8'h00);
        chk("R5", "wren with sequencer busy", status_o, 8'h01);
        array_busy = 1'b0;
        @(negedge clk);
        chk("R5", "busy input released", status_o, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule